// File: doc/BRIEF.md
# Paging Control Change Monitor

This block sits beside the control register file of a processor core. It watches writes to the paging controls (the CR0, CR3 and CR4 write strobes with their new values) and a set of side-band events. From them it produces single-cycle maintenance requests for the translation cache and for the four PAE page-directory-pointer registers (PDPTRs). It keeps masked shadow copies of the monitored CR0 and CR4 bits. A write is compared against the value held before it, which lets the block see rising and falling edges of each bit.

Flush requests come in two kinds: one that keeps global entries, and one that drops everything. PDPTR requests come in three kinds: reload from memory, save, and clear to zero. A static feature-enable vector decides which CR4 bits the block monitors. A configuration input adds an optional reload when certain CR4 feature bits change. Every request is registered, so it appears in the cycle after the strobe that caused it.

Top module: `pg_ctl_watch`

## Requirements
- R1: After reset all five outputs are low. Both shadows hold zero, so the first write that sets a monitored bit is seen as a 0-to-1 change.
- R2: A CR3 write always yields a flush in the next cycle. It is `tlb_flush_nonglobal` when CR4.PGE (bit 7) is enabled and set in the shadow. Otherwise it is `tlb_flush_all`.
- R3: A CR0 write that changes PE (bit 0), WP (bit 16) or PG (bit 31) yields `tlb_flush_all`.
- R4: A CR4 write that changes PSE (bit 4), PAE (bit 5), PGE (bit 7), PCIDE (bit 17) or SMEP (bit 20) yields `tlb_flush_all`. This applies only when the matching bit of `cr4_feat_en` is set; the bit order there is PSE=0, PAE=1, PGE=2, PCIDE=3, SMEP=4. A bit whose feature is disabled is stored as zero and never counts.
- R5: Each pulse on `ev_page_inval`, `ev_smm_resume`, `ev_mtrr_wr`, `ev_pat_wr`, `ev_apic_base_wr` or `ev_smm_entry` yields `tlb_flush_all`.
- R6: A CR3 write yields `pdpt_reload` when the shadow holds PG=1 and PAE=1.
- R7: `pdpt_reload` is raised when PG goes from 0 to 1 while the shadow PAE is 1. It is also raised when PAE goes from 0 to 1 while the shadow PG is 1.
- R8: `pdpt_clear` is raised when PG falls while the shadow PAE is 1. It is also raised when PAE falls while the shadow PG is 1.
- R9: `ev_smm_entry` raises `pdpt_save` in the next cycle and `pdpt_clear` in the cycle after that. `ev_smm_resume` raises `pdpt_reload`.
- R10: When `cfg_feat_reload` is 1, a change of an enabled PSE, PGE or SMEP bit also raises `pdpt_reload`. When it is 0, such a change does not.
- R11: When a full flush and a global-preserving flush fall due in the same cycle, only `tlb_flush_all` is raised.
- R12: A CR0 or CR4 write that changes no monitored bit raises nothing. If a clear and a reload fall due together, only `pdpt_clear` is raised.
- R13: Each request is high for exactly one cycle. It starts in the cycle after the strobe edge and uses the shadow values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr0_wr_en | input | 1 | CR0 write strobe |
| cr0_wr_data | input | CR_W | New CR0 value |
| cr3_wr_en | input | 1 | CR3 write strobe |
| cr4_wr_en | input | 1 | CR4 write strobe |
| cr4_wr_data | input | CR_W | New CR4 value |
| ev_page_inval | input | 1 | Single-page invalidate pulse |
| ev_smm_resume | input | 1 | Return from system-management mode |
| ev_mtrr_wr | input | 1 | Memory-range register write |
| ev_pat_wr | input | 1 | Page attribute table write |
| ev_apic_base_wr | input | 1 | Interrupt controller base write |
| ev_smm_entry | input | 1 | System-management interrupt taken |
| cr4_feat_en | input | 5 | Support flags for PSE, PAE, PGE, PCIDE, SMEP |
| cfg_feat_reload | input | 1 | Enables the optional reload on PSE/PGE/SMEP changes |
| tlb_flush_all | output | 1 | Flush every entry, including global ones |
| tlb_flush_nonglobal | output | 1 | Flush while keeping global entries |
| pdpt_reload | output | 1 | Reload the PDPTRs |
| pdpt_clear | output | 1 | Zero the PDPTRs |
| pdpt_save | output | 1 | Save the PDPTRs |

## Verification
A corrupt shadow bit hides until the next write to that register, or the next CR3 write. It then shows up in the cycle after that strobe in one of two ways. A spurious or missing `tlb_flush_all` appears on a rewrite of the same value. Or the wrong flush kind appears, or a reload or clear appears or goes missing, on a CR3 write or a PG/PAE edge. A lost SMM-entry delay flop shows two cycles after entry, as a missing `pdpt_clear`. The bench therefore rewrites unchanged values and alternates CR3 writes with PG and PAE edges, so that shadow faults surface within one cycle of the next strobe.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   localparam int CR0_FIELDS = 3;
   localparam int CR4_FIELDS = 5;

   // Architectural bit positions of the monitored fields
   localparam int CR0_POS [CR0_FIELDS] = '{0, 16, 31};
   localparam int CR4_POS [CR4_FIELDS] = '{4, 5, 7, 17, 20};

   // Field indices inside the compact vectors
   localparam int C0_PE    = 0;
   localparam int C0_WP    = 1;
   localparam int C0_PG    = 2;
   localparam int C4_PSE   = 0;
   localparam int C4_PAE   = 1;
   localparam int C4_PGE   = 2;
   localparam int C4_PCIDE = 3;
   localparam int C4_SMEP  = 4;

   // Fields whose change may optionally trigger a reload
   localparam logic [CR4_FIELDS-1:0] CR4_OPT_RELOAD =
      (CR4_FIELDS'(1) << C4_PSE) | (CR4_FIELDS'(1) << C4_PGE) | (CR4_FIELDS'(1) << C4_SMEP);

   typedef struct packed {
      logic flush_all;
      logic flush_ng;
      logic reload;
      logic clear;
      logic save;
   } pgw_act_t;

endpackage

// File: rtl/pgw_shadow.sv
module pgw_shadow #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);

   logic [W-1:0] nxt;

   if (W < 1) begin : g_bad_w
      $error("pgw_shadow: W must be at least 1");
   end

   assign nxt  = wdata & mask;
   assign rise = {W{we}} & nxt & ~q;
   assign fall = {W{we}} & ~nxt & q;

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= nxt;
   end

endmodule

// File: rtl/pgw_action_gen.sv
module pgw_action_gen
   import pgw_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CR0_FIELDS-1:0] c0_q,
   input  logic [CR0_FIELDS-1:0] c0_rise,
   input  logic [CR0_FIELDS-1:0] c0_fall,
   input  logic [CR4_FIELDS-1:0] c4_q,
   input  logic [CR4_FIELDS-1:0] c4_rise,
   input  logic [CR4_FIELDS-1:0] c4_fall,
   input  logic                  cr3_we,
   input  logic                  ev_flush,
   input  logic                  ev_resume,
   input  logic                  ev_smi,
   input  logic                  cfg_opt,
   output pgw_act_t              act_q
);

   logic     pg_now, pae_now, pge_now, smi_d;
   logic     full_req, ng_req, rld_raw, clr_req;
   pgw_act_t act_d;

   always_comb begin
      pg_now   = c0_q[C0_PG];
      pae_now  = c4_q[C4_PAE];
      pge_now  = c4_q[C4_PGE];
      full_req = (|c0_rise) | (|c0_fall) | (|c4_rise) | (|c4_fall)
               | ev_flush | (cr3_we & ~pge_now);
      ng_req   = cr3_we & pge_now & ~full_req;
      clr_req  = (c0_fall[C0_PG] & pae_now) | (c4_fall[C4_PAE] & pg_now) | smi_d;
      rld_raw  = (cr3_we & pg_now & pae_now)
               | (c0_rise[C0_PG] & pae_now)
               | (c4_rise[C4_PAE] & pg_now)
               | ev_resume
               | (cfg_opt & (|((c4_rise | c4_fall) & CR4_OPT_RELOAD)));
      act_d.flush_all = full_req;
      act_d.flush_ng  = ng_req;
      act_d.reload    = rld_raw & ~clr_req;
      act_d.clear     = clr_req;
      act_d.save      = ev_smi;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= '0;
         smi_d <= 1'b0;
      end else begin
         act_q <= act_d;
         smi_d <= ev_smi;
      end
   end

endmodule

// File: rtl/pg_ctl_watch.sv
module pg_ctl_watch
   import pgw_pkg::*;
#(
   parameter int CR_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cr0_wr_en,
   input  logic [CR_W-1:0]       cr0_wr_data,
   input  logic                  cr3_wr_en,
   input  logic                  cr4_wr_en,
   input  logic [CR_W-1:0]       cr4_wr_data,
   input  logic                  ev_page_inval,
   input  logic                  ev_smm_resume,
   input  logic                  ev_mtrr_wr,
   input  logic                  ev_pat_wr,
   input  logic                  ev_apic_base_wr,
   input  logic                  ev_smm_entry,
   input  logic [CR4_FIELDS-1:0] cr4_feat_en,
   input  logic                  cfg_feat_reload,
   output logic                  tlb_flush_all,
   output logic                  tlb_flush_nonglobal,
   output logic                  pdpt_reload,
   output logic                  pdpt_clear,
   output logic                  pdpt_save
);

   localparam logic [CR0_FIELDS-1:0] CR0_KEEP = '1;

   logic [CR0_FIELDS-1:0] c0_sel, c0_q, c0_rise, c0_fall;
   logic [CR4_FIELDS-1:0] c4_sel, c4_q, c4_rise, c4_fall;
   logic                  ev_flush;
   pgw_act_t              act;

   for (genvar i = 0; i < CR0_FIELDS; i++) begin : g_cr0_pick
      if (CR0_POS[i] >= CR_W) begin : g_bad
         $error("pg_ctl_watch: CR0 field beyond CR_W");
      end
      assign c0_sel[i] = cr0_wr_data[CR0_POS[i]];
   end

   for (genvar i = 0; i < CR4_FIELDS; i++) begin : g_cr4_pick
      if (CR4_POS[i] >= CR_W) begin : g_bad
         $error("pg_ctl_watch: CR4 field beyond CR_W");
      end
      assign c4_sel[i] = cr4_wr_data[CR4_POS[i]];
   end

   pgw_shadow #(.W(CR0_FIELDS)) u_cr0_sh (
      .clk(clk), .rst_n(rst_n), .we(cr0_wr_en), .wdata(c0_sel), .mask(CR0_KEEP),
      .q(c0_q), .rise(c0_rise), .fall(c0_fall)
   );

   pgw_shadow #(.W(CR4_FIELDS)) u_cr4_sh (
      .clk(clk), .rst_n(rst_n), .we(cr4_wr_en), .wdata(c4_sel), .mask(cr4_feat_en),
      .q(c4_q), .rise(c4_rise), .fall(c4_fall)
   );

   assign ev_flush = ev_page_inval | ev_smm_resume | ev_mtrr_wr | ev_pat_wr
                   | ev_apic_base_wr | ev_smm_entry;

   pgw_action_gen u_act (
      .clk(clk), .rst_n(rst_n),
      .c0_q(c0_q), .c0_rise(c0_rise), .c0_fall(c0_fall),
      .c4_q(c4_q), .c4_rise(c4_rise), .c4_fall(c4_fall),
      .cr3_we(cr3_wr_en), .ev_flush(ev_flush), .ev_resume(ev_smm_resume),
      .ev_smi(ev_smm_entry), .cfg_opt(cfg_feat_reload), .act_q(act)
   );

   assign tlb_flush_all       = act.flush_all;
   assign tlb_flush_nonglobal = act.flush_ng;
   assign pdpt_reload         = act.reload;
   assign pdpt_clear          = act.clear;
   assign pdpt_save           = act.save;

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker (
   input logic clk,
   input logic rst_n,
   input logic cr3_wr_en,
   input logic ev_page_inval,
   input logic ev_smm_resume,
   input logic ev_mtrr_wr,
   input logic ev_pat_wr,
   input logic ev_apic_base_wr,
   input logic ev_smm_entry,
   input logic tlb_flush_all,
   input logic tlb_flush_nonglobal,
   input logic pdpt_reload,
   input logic pdpt_clear,
   input logic pdpt_save
);

   AST_FLUSH_KIND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(tlb_flush_all && tlb_flush_nonglobal)); // R11

   AST_PDPT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pdpt_clear && pdpt_reload)); // R12

   AST_CR3_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
      cr3_wr_en |=> (tlb_flush_all || tlb_flush_nonglobal)); // R2

   AST_NG_FROM_CR3: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush_nonglobal |-> $past(cr3_wr_en)); // R2

   AST_EVENT_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_page_inval || ev_smm_resume || ev_mtrr_wr || ev_pat_wr ||
       ev_apic_base_wr || ev_smm_entry) |=> tlb_flush_all); // R5

   AST_SMI_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_smm_entry |=> pdpt_save); // R9

   AST_SAVE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      pdpt_save |-> $past(ev_smm_entry)); // R9

   AST_SAVE_THEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      pdpt_save |=> pdpt_clear); // R9

endmodule

bind pg_ctl_watch pgw_checker u_pgw_chk (
   .clk(clk), .rst_n(rst_n), .cr3_wr_en(cr3_wr_en),
   .ev_page_inval(ev_page_inval), .ev_smm_resume(ev_smm_resume),
   .ev_mtrr_wr(ev_mtrr_wr), .ev_pat_wr(ev_pat_wr),
   .ev_apic_base_wr(ev_apic_base_wr), .ev_smm_entry(ev_smm_entry),
   .tlb_flush_all(tlb_flush_all), .tlb_flush_nonglobal(tlb_flush_nonglobal),
   .pdpt_reload(pdpt_reload), .pdpt_clear(pdpt_clear), .pdpt_save(pdpt_save)
);

// File: tb/tb_pg_ctl_watch.sv
`timescale 1ns/1ps
module tb_pg_ctl_watch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cr0_wr_en = 0, cr3_wr_en = 0, cr4_wr_en = 0;
   logic [31:0] cr0_wr_data = '0, cr4_wr_data = '0;
   logic        ev_page_inval = 0, ev_smm_resume = 0, ev_mtrr_wr = 0;
   logic        ev_pat_wr = 0, ev_apic_base_wr = 0, ev_smm_entry = 0;
   logic [4:0]  cr4_feat_en = 5'b11111;
   logic        cfg_feat_reload = 0;
   logic        tlb_flush_all, tlb_flush_nonglobal, pdpt_reload, pdpt_clear, pdpt_save;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #2.5 clk = ~clk;

   pg_ctl_watch dut (.*);

   // ---------------- behavioural reference model ----------------
   bit [31:0] m_cr0, m_cr4;
   bit        m_smi_pend;
   bit [4:0]  m_exp;   // {flush_all, flush_ng, reload, clear, save}

   function automatic bit [31:0] feat_mask(input logic [4:0] f);
      bit [31:0] m = 0;
      if (f[0]) m[4]  = 1;
      if (f[1]) m[5]  = 1;
      if (f[2]) m[7]  = 1;
      if (f[3]) m[17] = 1;
      if (f[4]) m[20] = 1;
      return m;
   endfunction

   always @(posedge clk) begin : model
      bit [31:0] fm, new4;
      bit pg_o, pae_o, pge_o, pg_n, pae_n, fa, ng, rl, cl, c0chg, c4chg, opt;
      if (!rst_n) begin
         m_cr0 <= 0; m_cr4 <= 0; m_smi_pend <= 0; m_exp <= 0;
      end else begin
         fm    = feat_mask(cr4_feat_en);
         new4  = cr4_wr_data & fm;
         pg_o  = m_cr0[31];
         pae_o = m_cr4[5];
         pge_o = m_cr4[7];
         pg_n  = cr0_wr_en ? cr0_wr_data[31] : pg_o;
         pae_n = cr4_wr_en ? new4[5] : pae_o;
         c0chg = cr0_wr_en && ((cr0_wr_data & 32'h8001_0001) != (m_cr0 & 32'h8001_0001));
         c4chg = cr4_wr_en && (new4 != m_cr4);
         opt   = cr4_wr_en && cfg_feat_reload && ((new4 & 32'h0010_0090) != (m_cr4 & 32'h0010_0090));
         fa = c0chg || c4chg || ev_page_inval || ev_smm_resume || ev_mtrr_wr ||
              ev_pat_wr || ev_apic_base_wr || ev_smm_entry || (cr3_wr_en && !pge_o);
         ng = cr3_wr_en && pge_o && !fa;
         cl = (pg_o && !pg_n && pae_o) || (pae_o && !pae_n && pg_o) || m_smi_pend;
         rl = (cr3_wr_en && pg_o && pae_o) || (!pg_o && pg_n && pae_o) ||
              (!pae_o && pae_n && pg_o) || ev_smm_resume || opt;
         rl = rl && !cl;
         m_exp      <= {fa, ng, rl, cl, ev_smm_entry};
         m_smi_pend <= ev_smm_entry;
         if (cr0_wr_en) m_cr0 <= cr0_wr_data & 32'h8001_0001;
         if (cr4_wr_en) m_cr4 <= new4;
      end
   end

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_checks++;
         if ({tlb_flush_all, tlb_flush_nonglobal, pdpt_reload, pdpt_clear, pdpt_save} != m_exp) begin
            n_fail++;
            $display("FAIL R13 model compare t=%0t actual=%b expected=%b", $time,
               {tlb_flush_all, tlb_flush_nonglobal, pdpt_reload, pdpt_clear, pdpt_save}, m_exp);
         end
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic cyc(input bit c0we, input bit [31:0] c0, input bit c3we,
                      input bit c4we, input bit [31:0] c4, input bit [5:0] ev);
      cr0_wr_en = c0we; cr0_wr_data = c0; cr3_wr_en = c3we;
      cr4_wr_en = c4we; cr4_wr_data = c4;
      {ev_page_inval, ev_smm_resume, ev_mtrr_wr, ev_pat_wr, ev_apic_base_wr, ev_smm_entry} = ev;
      @(negedge clk);
      cr0_wr_en = 0; cr3_wr_en = 0; cr4_wr_en = 0;
      {ev_page_inval, ev_smm_resume, ev_mtrr_wr, ev_pat_wr, ev_apic_base_wr, ev_smm_entry} = '0;
   endtask

   task automatic expect5(input string tag, input bit [4:0] exp);
      bit [4:0] act = {tlb_flush_all, tlb_flush_nonglobal, pdpt_reload, pdpt_clear, pdpt_save};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   localparam bit [5:0] EV_INV = 6'b100000, EV_RSM = 6'b010000, EV_MTRR = 6'b001000;
   localparam bit [5:0] EV_PAT = 6'b000100, EV_APIC = 6'b000010, EV_SMI = 6'b000001;

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      expect5("R1 reset outputs", 5'b00000);
      cyc(0, 0, 1, 0, 0, 0);               expect5("R2 cr3 no PGE -> full", 5'b10000);
      cyc(0, 0, 0, 1, 32'h80, 0);          expect5("R4 PGE set flush", 5'b10000);
      cyc(0, 0, 1, 0, 0, 0);               expect5("R2 cr3 PGE -> nonglobal", 5'b01000);
      cyc(0, 0, 0, 1, 32'hA0, 0);          expect5("R4 PAE set, PG off", 5'b10000);
      cyc(1, 32'h8000_0001, 0, 0, 0, 0);   expect5("R7 R3 PG rise with PAE", 5'b10100);
      cyc(0, 0, 1, 0, 0, 0);               expect5("R6 cr3 reload", 5'b01100);
      cyc(1, 32'h8000_0001, 0, 0, 0, 0);   expect5("R12 same CR0 rewrite", 5'b00000);
      cyc(0, 0, 0, 1, 32'hA0, 0);          expect5("R12 same CR4 rewrite", 5'b00000);
      cyc(0, 0, 0, 1, 32'h80, 0);          expect5("R8 PAE fall clear", 5'b10010);
      cyc(0, 0, 0, 1, 32'hA0, 0);          expect5("R7 PAE rise with PG", 5'b10100);
      cyc(1, 32'h8001_0001, 0, 0, 0, 0);   expect5("R3 WP change", 5'b10000);
      cfg_feat_reload = 1;
      cyc(0, 0, 0, 1, 32'hB0, 0);          expect5("R10 PSE change reload", 5'b10100);
      cfg_feat_reload = 0;
      cyc(0, 0, 0, 1, 32'hA0, 0);          expect5("R10 option off", 5'b10000);
      cyc(0, 0, 0, 0, 0, EV_SMI);          expect5("R9 smi save", 5'b10001);
      cyc(0, 0, 0, 0, 0, 0);               expect5("R9 smi clear after save", 5'b00010);
      cyc(0, 0, 0, 0, 0, 0);               expect5("R13 pulse ends", 5'b00000);
      cyc(0, 0, 0, 0, 0, EV_RSM);          expect5("R9 R5 resume reload", 5'b10100);
      cyc(0, 0, 0, 0, 0, EV_INV);          expect5("R5 page invalidate", 5'b10000);
      cyc(0, 0, 0, 0, 0, EV_MTRR);         expect5("R5 mtrr write", 5'b10000);
      cyc(0, 0, 0, 0, 0, EV_PAT);          expect5("R5 pat write", 5'b10000);
      cyc(0, 0, 0, 0, 0, EV_APIC);         expect5("R5 apic base write", 5'b10000);
      cyc(1, 32'h0001_0001, 1, 0, 0, 0);   expect5("R11 R12 full wins, clear wins", 5'b10010);
      cr4_feat_en = 5'b10111;
      cyc(0, 0, 0, 1, 32'h0002_00A0, 0);   expect5("R4 disabled PCIDE ignored", 5'b00000);
      cr4_feat_en = 5'b11111;
      cyc(0, 0, 0, 1, 32'h0002_00A0, 0);   expect5("R4 enabled PCIDE flush", 5'b10000);
      cyc(0, 0, 0, 0, 0, 0);               expect5("R13 idle", 5'b00000);
      repeat (2) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule